// File: doc/BRIEF.md
# DMA Read-Write Sequencer with Fault Handling

This block is the transfer engine of one DMA channel. A start pulse loads a descriptor (source address, destination address, signed source and destination offsets, and a count of read-write pairs). The engine then moves one 32-bit word per pair: it reads from the source address and writes the captured word to the destination address. Every access goes over a simple bus master port that has a request/grant handshake, one access outstanding at a time, and a response that can flag an error.

The engine defines exactly what happens on bus faults and on cancel requests. An access that is already under way always finishes before the channel stops. A cancel that arrives during the final pair is dropped, and the channel then retires normally. A terminated channel does not raise its done flag. It stays usable, so a restart with the same fault ends the same way. The current source address, destination address and remaining count are presented at all times for write-back into the descriptor. After a fault or cancel they show the values at the point where the channel stopped.

Top module: `dma_rw_sequencer`

## Requirements
- R1: A start pulse while idle loads the descriptor and clears all status flags. A start pulse while the engine is busy has no effect on the transfer.
- R2: Each pair reads the source address and then writes the word it read to the destination address. The source address advances by the sign-extended 16-bit source offset after every completed read. The destination address advances by the sign-extended destination offset after every completed write. The count drops by one after every completed write.
- R3: `busReq` stays high, with address, direction and write data stable, until `busGnt` is seen. The next request is issued only after the response (`busRspValid`) has been accepted. No request is made while the engine is idle.
- R4: When the count reaches zero with no fault and no accepted cancel, `doneFlag` is set and `busy` drops. A start with a count of zero sets `doneFlag` without any bus access.
- R5: An error response to a read sets `errSrcFlag`. The following write is still performed, using the word captured with the errored read. The channel then terminates.
- R6: An error response to a write sets `errDstFlag`. If pairs remain, exactly one more read is performed (and the source address advances) before the channel terminates. If it was the last write, the channel terminates at once.
- R7: A cancel request during a pair other than the final one lets that pair finish (read and write), then terminates the channel.
- R8: A cancel or error-cancel request during the final pair (count equal to 1) is discarded, and the channel completes normally with `doneFlag` set.
- R9: An error-cancel request behaves like a cancel and also sets `errCancelFlag` whenever it is accepted.
- R10: `terminated` is a pulse lasting exactly one cycle and is never high while `doneFlag` is set. After termination the write-back outputs keep the stopping-point values until the next start.
- R11: A terminated channel can be restarted. The same descriptor with the same fault gives the same accesses, flags and write-back values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| startValid | input | 1 | Start pulse; loads the descriptor when idle |
| startSrc | input | 32 | Initial source address |
| startDst | input | 32 | Initial destination address |
| startSrcOff | input | 16 | Signed source offset |
| startDstOff | input | 16 | Signed destination offset |
| startCount | input | 16 | Number of read-write pairs |
| cancelReq | input | 1 | Cancel request |
| errCancelReq | input | 1 | Cancel request that is also logged as an error |
| busReq | output | 1 | Bus access request |
| busWrite | output | 1 | 1 for a write, 0 for a read |
| busAddr | output | 32 | Access address |
| busWdata | output | 32 | Write data |
| busGnt | input | 1 | Grant for the pending request |
| busRspValid | input | 1 | Access response |
| busRspErr | input | 1 | Error qualifier of the response |
| busRdata | input | 32 | Read data with the response |
| busy | output | 1 | A transfer is in progress |
| doneFlag | output | 1 | Sticky: transfer completed normally |
| terminated | output | 1 | One-cycle pulse when the channel stops early |
| errSrcFlag | output | 1 | Sticky: a read returned an error |
| errDstFlag | output | 1 | Sticky: a write returned an error |
| errCancelFlag | output | 1 | Sticky: an error-cancel was accepted |
| wbSrcAddr | output | 32 | Current source address for write-back |
| wbDstAddr | output | 32 | Current destination address for write-back |
| wbCount | output | 16 | Remaining pair count for write-back |

## Verification
The bench places read errors on the first and on the last read. A design that skipped the pipelined write would show one write too few and a stale destination address. A design that took the error as a normal completion would set `doneFlag`. Write errors are placed both in mid-transfer and on the final write. A design that skipped the extra read, or performed one after the last pair, would show an access count or a source write-back value that is off by one access. Cancels are placed on both halves of a middle pair and on the final pair. A design that stopped mid-pair, ignored the cancel, or honoured a cancel on the final pair would end with the wrong access count or the wrong flag. The remaining checks cover a zero count, a start while busy, and a repeated faulted restart. In each case a wrong design would either touch the bus or disturb the transfer, or end differently on the second run.

// File: rtl/dma_rw_seq_pkg.sv
package dma_rw_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_WRITE = 3'd2,
    ST_TERM  = 3'd3,
    ST_DONE  = 3'd4
  } seqState_t;

  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic load;         // accept descriptor, clear flags
    logic rdDone;       // read response accepted: capture data, step source
    logic wrDone;       // write response accepted: step destination, count down
    logic setErrSrc;
    logic setErrDst;
    logic setErrCancel;
    logic setDone;
  } seqStrobe_t;

endpackage

// File: rtl/dma_rw_seq_dp.sv
module dma_rw_seq_dp
  import dma_rw_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] startSrc,
  input  logic [ADDR_W-1:0] startDst,
  input  logic [OFF_W-1:0]  startSrcOff,
  input  logic [OFF_W-1:0]  startDstOff,
  input  logic [CNT_W-1:0]  startCount,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] dataHold,
  output logic              errSrc,
  output logic              errDst,
  output logic              errCancel,
  output logic              doneSticky,
  output logic              lastPair
);

  localparam int EXT_W = ADDR_W - OFF_W;

  logic [OFF_W-1:0]  srcOffQ;
  logic [OFF_W-1:0]  dstOffQ;
  logic [ADDR_W-1:0] srcStep;
  logic [ADDR_W-1:0] dstStep;

  assign srcStep  = {{EXT_W{srcOffQ[OFF_W-1]}}, srcOffQ};
  assign dstStep  = {{EXT_W{dstOffQ[OFF_W-1]}}, dstOffQ};
  assign lastPair = (count == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcAddr    <= '0;
      dstAddr    <= '0;
      srcOffQ    <= '0;
      dstOffQ    <= '0;
      count      <= '0;
      dataHold   <= '0;
      errSrc     <= 1'b0;
      errDst     <= 1'b0;
      errCancel  <= 1'b0;
      doneSticky <= 1'b0;
    end else if (strobe.load) begin
      srcAddr    <= startSrc;
      dstAddr    <= startDst;
      srcOffQ    <= startSrcOff;
      dstOffQ    <= startDstOff;
      count      <= startCount;
      errSrc     <= 1'b0;
      errDst     <= 1'b0;
      errCancel  <= 1'b0;
      doneSticky <= 1'b0;
    end else begin
      if (strobe.rdDone) begin
        dataHold <= busRdata;
        srcAddr  <= srcAddr + srcStep;
      end
      if (strobe.wrDone) begin
        dstAddr <= dstAddr + dstStep;
        count   <= count - CNT_W'(1);
      end
      if (strobe.setErrSrc)    errSrc     <= 1'b1;
      if (strobe.setErrDst)    errDst     <= 1'b1;
      if (strobe.setErrCancel) errCancel  <= 1'b1;
      if (strobe.setDone)      doneSticky <= 1'b1;
    end
  end

endmodule

// File: rtl/dma_rw_seq_ctrl.sv
module dma_rw_seq_ctrl
  import dma_rw_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic       startZero,
  input  logic       cancelReq,
  input  logic       errCancelReq,
  input  logic       busGnt,
  input  logic       busRspValid,
  input  logic       busRspErr,
  input  logic       lastPair,
  output seqStrobe_t strobe,
  output logic       busReq,
  output logic       busWrite,
  output logic       busy,
  output logic       terminated
);

  seqState_t state, stateNext;
  logic waitRsp;
  logic stopAfterWrite;   // a read faulted: finish this write, then stop
  logic stopAfterRead;    // a write faulted: finish next read, then stop
  logic cancelPend;

  logic active, rspTake, cancelNow;

  assign active     = (state == ST_READ) || (state == ST_WRITE);
  assign busReq     = active && !waitRsp;
  assign busWrite   = (state == ST_WRITE);
  assign busy       = (state != ST_IDLE);
  assign terminated = (state == ST_TERM);
  assign rspTake    = active && waitRsp && busRspValid;
  assign cancelNow  = (cancelReq || errCancelReq) && active && !lastPair;

  always_comb begin
    strobe              = '0;
    strobe.load         = (state == ST_IDLE) && startValid;
    strobe.rdDone       = rspTake && (state == ST_READ);
    strobe.wrDone       = rspTake && (state == ST_WRITE);
    strobe.setErrSrc    = strobe.rdDone && busRspErr;
    strobe.setErrDst    = strobe.wrDone && busRspErr;
    strobe.setErrCancel = errCancelReq && active && !lastPair;
    strobe.setDone      = (state == ST_DONE);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (strobe.load) stateNext = startZero ? ST_DONE : ST_READ;
      ST_READ:  if (strobe.rdDone) stateNext = stopAfterRead ? ST_TERM : ST_WRITE;
      ST_WRITE: begin
        if (strobe.wrDone) begin
          if (lastPair)                    stateNext = (busRspErr || stopAfterWrite) ? ST_TERM : ST_DONE;
          else if (stopAfterWrite)         stateNext = ST_TERM;
          else if (busRspErr)              stateNext = ST_READ;
          else if (cancelPend || cancelNow) stateNext = ST_TERM;
          else                             stateNext = ST_READ;
        end
      end
      ST_TERM:  stateNext = ST_IDLE;
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state          <= ST_IDLE;
      waitRsp        <= 1'b0;
      stopAfterWrite <= 1'b0;
      stopAfterRead  <= 1'b0;
      cancelPend     <= 1'b0;
    end else begin
      state <= stateNext;
      if (rspTake)                waitRsp <= 1'b0;
      else if (busReq && busGnt)  waitRsp <= 1'b1;
      if (strobe.load) begin
        stopAfterWrite <= 1'b0;
        stopAfterRead  <= 1'b0;
        cancelPend     <= 1'b0;
      end else begin
        if (strobe.setErrSrc) stopAfterWrite <= 1'b1;
        if (strobe.setErrDst && !lastPair) stopAfterRead <= 1'b1;
        if (cancelNow) cancelPend <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dma_rw_sequencer.sv
module dma_rw_sequencer
  import dma_rw_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [ADDR_W-1:0] startSrc,
  input  logic [ADDR_W-1:0] startDst,
  input  logic [OFF_W-1:0]  startSrcOff,
  input  logic [OFF_W-1:0]  startDstOff,
  input  logic [CNT_W-1:0]  startCount,
  input  logic              cancelReq,
  input  logic              errCancelReq,
  output logic              busReq,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busGnt,
  input  logic              busRspValid,
  input  logic              busRspErr,
  input  logic [DATA_W-1:0] busRdata,
  output logic              busy,
  output logic              doneFlag,
  output logic              terminated,
  output logic              errSrcFlag,
  output logic              errDstFlag,
  output logic              errCancelFlag,
  output logic [ADDR_W-1:0] wbSrcAddr,
  output logic [ADDR_W-1:0] wbDstAddr,
  output logic [CNT_W-1:0]  wbCount
);

  seqStrobe_t strobe;
  logic       lastPair;
  logic       startZero;

  assign startZero = (startCount == '0);

  dma_rw_seq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .startValid   (startValid),
    .startZero    (startZero),
    .cancelReq    (cancelReq),
    .errCancelReq (errCancelReq),
    .busGnt       (busGnt),
    .busRspValid  (busRspValid),
    .busRspErr    (busRspErr),
    .lastPair     (lastPair),
    .strobe       (strobe),
    .busReq       (busReq),
    .busWrite     (busWrite),
    .busy         (busy),
    .terminated   (terminated)
  );

  dma_rw_seq_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .OFF_W  (OFF_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .startSrc    (startSrc),
    .startDst    (startDst),
    .startSrcOff (startSrcOff),
    .startDstOff (startDstOff),
    .startCount  (startCount),
    .busRdata    (busRdata),
    .srcAddr     (wbSrcAddr),
    .dstAddr     (wbDstAddr),
    .count       (wbCount),
    .dataHold    (busWdata),
    .errSrc      (errSrcFlag),
    .errDst      (errDstFlag),
    .errCancel   (errCancelFlag),
    .doneSticky  (doneFlag),
    .lastPair    (lastPair)
  );

  assign busAddr = busWrite ? wbDstAddr : wbSrcAddr;

endmodule

// File: rtl/dma_rw_seq_sva.sv
module dma_rw_seq_sva #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              busGnt,
  input logic              busRspValid,
  input logic              busRspErr,
  input logic              busy,
  input logic              doneFlag,
  input logic              terminated,
  input logic              errSrcFlag,
  input logic              errDstFlag,
  input logic              errCancelFlag,
  input logic [CNT_W-1:0]  wbCount
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busGnt |=> busReq && $stable(busAddr) && $stable(busWrite) && $stable(busWdata)); // R3

  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !busReq); // R3

  AST_TERM_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    terminated |=> !terminated); // R10

  AST_TERM_NOT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    terminated |-> !doneFlag); // R10

  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> !errSrcFlag && !errDstFlag && !errCancelFlag); // R4

  AST_RD_ERR_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    busy && busRspValid && busRspErr && !busWrite && !errDstFlag |=> busReq && busWrite); // R5

  AST_WR_ERR_READ: assert property (@(posedge clk) disable iff (!rstN)
    busy && busRspValid && busRspErr && busWrite && !errSrcFlag && (wbCount != CNT_W'(1))
    |=> busReq && !busWrite); // R6

endmodule

bind dma_rw_sequencer dma_rw_seq_sva #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W)
) u_sva (.*);

// File: tb/tb_dma_rw_sequencer.sv
module tb_dma_rw_sequencer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [31:0] startSrc = '0, startDst = '0;
  logic [15:0] startSrcOff = '0, startDstOff = '0, startCount = '0;
  logic        cancelReq = 1'b0, errCancelReq = 1'b0;
  logic        busReq, busWrite;
  logic [31:0] busAddr, busWdata;
  logic        busGnt = 1'b0, busRspValid = 1'b0, busRspErr = 1'b0;
  logic [31:0] busRdata = '0;
  logic        busy, doneFlag, terminated, errSrcFlag, errDstFlag, errCancelFlag;
  logic [31:0] wbSrcAddr, wbDstAddr;
  logic [15:0] wbCount;

  always #5 clk = ~clk;

  dma_rw_sequencer dut (.*);

  int checks = 0;
  int fails  = 0;

  // Fault and cancel scenario used by the bus model
  int errIdx = -1;
  int cancelKind = 0;   // 0 none, 1 cancel, 2 error-cancel
  int cancelIdx = -1;

  // Recorded accesses
  logic        recW [64];
  logic [31:0] recA [64];
  logic [31:0] recD [64];
  int          recN = 0;

  // Expected results
  logic        expW [64];
  logic [31:0] expA [64];
  logic [31:0] expD [64];
  int          expN;
  bit          expErrS, expErrD, expXc, expDone;
  logic [31:0] expS, expDst;
  logic [15:0] expC;

  function automatic logic [31:0] memWord(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [31:0] sx(logic [15:0] o);
    return {{16{o[15]}}, o};
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Bus slave model, driven away from the active edge
  initial begin
    bit pend = 0;
    int lat = 0;
    int pIdx = 0;
    logic [31:0] pAddr = '0;
    forever begin
      @(negedge clk);
      busGnt = 0; busRspValid = 0; busRspErr = 0; cancelReq = 0; errCancelReq = 0;
      if (pend) begin
        if (lat == 0) begin
          busRspValid = 1;
          busRdata    = memWord(pAddr);
          busRspErr   = (pIdx == errIdx);
          pend = 0;
        end else lat--;
      end else if (busReq && ($urandom % 3 != 0)) begin
        busGnt = 1;
        if (recN < 64) begin
          recW[recN] = busWrite;
          recA[recN] = busAddr;
          recD[recN] = busWrite ? busWdata : memWord(busAddr);
        end
        pend = 1; lat = $urandom % 3; pIdx = recN; pAddr = busAddr;
        if (recN == cancelIdx) begin
          if (cancelKind == 1) cancelReq = 1;
          if (cancelKind == 2) errCancelReq = 1;
        end
        recN++;
      end
    end
  end

  task automatic addExp(logic w, logic [31:0] a, logic [31:0] d);
    if (expN < 64) begin expW[expN] = w; expA[expN] = a; expD[expN] = d; end
    expN++;
  endtask

  // Reference outcome computed from the requirements
  task automatic buildExpected(logic [31:0] s0, logic [31:0] d0, logic [15:0] so, logic [15:0] dof, int n0);
    logic [31:0] s, d, data;
    int n, idx;
    bit rdErr, wrErr, stopRd, canc, last;
    s = s0; d = d0; n = n0; idx = 0; stopRd = 0;
    expN = 0; expErrS = 0; expErrD = 0; expXc = 0; expDone = 0;
    if (n == 0) expDone = 1;
    else begin
      forever begin
        addExp(1'b0, s, memWord(s));
        data = memWord(s);
        rdErr = (idx == errIdx);
        if (rdErr) expErrS = 1;
        s = s + sx(so); idx++;
        if (stopRd) break;
        canc = (cancelKind != 0) && (n != 1) && (cancelIdx == idx - 1 || cancelIdx == idx);
        if (canc && cancelKind == 2) expXc = 1;
        addExp(1'b1, d, data);
        wrErr = (idx == errIdx);
        if (wrErr) expErrD = 1;
        d = d + sx(dof); last = (n == 1); n--; idx++;
        if (last) begin
          if (!(rdErr || wrErr)) expDone = 1;
          break;
        end
        if (rdErr) break;
        if (wrErr) begin stopRd = 1; continue; end
        if (canc) break;
      end
    end
    expS = s; expDst = d; expC = 16'(n);
  endtask

  task automatic runCase(string tag, logic [31:0] s0, logic [31:0] d0, logic [15:0] so,
                         logic [15:0] dof, int n0, int eIdx, int cKind, int cIdx, bit busyStart);
    int cyc;
    bit sawTerm;
    errIdx = eIdx; cancelKind = cKind; cancelIdx = cIdx; recN = 0;
    buildExpected(s0, d0, so, dof, n0);
    @(negedge clk);
    startSrc = s0; startDst = d0; startSrcOff = so; startDstOff = dof; startCount = 16'(n0);
    startValid = 1;
    @(negedge clk);
    startValid = 0;
    if (busyStart) begin
      @(negedge clk);
      startSrc = s0 + 32'h1000; startDst = d0 + 32'h2000; startCount = 16'd1; startValid = 1;
      @(negedge clk);
      startValid = 0;
    end
    cyc = 0;
    while (!(terminated || doneFlag) && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc < 5000, tag, "transfer never ended", 32'(cyc), 32'd5000);
    sawTerm = terminated;
    @(negedge clk);
    check(!terminated, "R10", "terminated longer than one cycle", 32'(terminated), 32'd0);
    repeat (2) @(negedge clk);
    check(sawTerm == !expDone, tag, "terminated seen", 32'(sawTerm), 32'(!expDone));
    check(doneFlag == expDone, tag, "doneFlag", 32'(doneFlag), 32'(expDone));
    check(errSrcFlag == expErrS, tag, "errSrcFlag", 32'(errSrcFlag), 32'(expErrS));
    check(errDstFlag == expErrD, tag, "errDstFlag", 32'(errDstFlag), 32'(expErrD));
    check(errCancelFlag == expXc, tag, "errCancelFlag", 32'(errCancelFlag), 32'(expXc));
    check(wbSrcAddr == expS, tag, "wbSrcAddr", wbSrcAddr, expS);
    check(wbDstAddr == expDst, tag, "wbDstAddr", wbDstAddr, expDst);
    check(wbCount == expC, tag, "wbCount", 32'(wbCount), 32'(expC));
    check(!busy, "R4", "busy after end", 32'(busy), 32'd0);
    check(recN == expN, tag, "access count", 32'(recN), 32'(expN));
    for (int i = 0; i < expN && i < recN && i < 64; i++) begin
      check(recW[i] == expW[i] && recA[i] == expA[i] && recD[i] == expD[i], "R2",
            $sformatf("access %0d (write=%0d addr)", i, recW[i]), recA[i] ^ recD[i], expA[i] ^ expD[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20517));
    repeat (3) @(negedge clk);
    check(!busy && !busReq && !doneFlag && !terminated, "R1", "reset state",
          {28'd0, busy, busReq, doneFlag, terminated}, 32'd0);
    rstN = 1;
    repeat (2) @(negedge clk);

    runCase("R2", 32'h0000_1000, 32'h0000_8000, 16'd4, 16'd4, 4, -1, 0, -1, 0);
    runCase("R5", 32'h0000_2000, 32'h0000_9000, 16'd4, 16'hFFFC, 3, 0, 0, -1, 0);   // first read faults
    runCase("R5", 32'h0000_3000, 32'h0000_A000, 16'd8, 16'd4, 3, 4, 0, -1, 0);      // last read faults
    runCase("R6", 32'h0000_4000, 32'h0000_B000, 16'd4, 16'd4, 3, 1, 0, -1, 0);      // mid write faults
    runCase("R6", 32'h0000_5000, 32'h0000_C000, 16'hFFF0, 16'd4, 3, 5, 0, -1, 0);   // last write faults
    runCase("R1", 32'h0000_6000, 32'h0000_D000, 16'd4, 16'd4, 2, -1, 0, -1, 0);     // flags cleared again
    runCase("R7", 32'h0000_7000, 32'h0000_E000, 16'd4, 16'd4, 4, -1, 1, 2, 0);      // cancel on a read
    runCase("R7", 32'h0000_7100, 32'h0000_E100, 16'd4, 16'd4, 4, -1, 1, 3, 0);      // cancel on a write
    runCase("R8", 32'h0000_7200, 32'h0000_E200, 16'd4, 16'd4, 3, -1, 1, 4, 0);      // cancel on final pair
    runCase("R9", 32'h0000_7300, 32'h0000_E300, 16'd4, 16'd4, 3, -1, 2, 1, 0);
    runCase("R8", 32'h0000_7400, 32'h0000_E400, 16'd4, 16'd4, 3, -1, 2, 5, 0);      // error-cancel discarded
    runCase("R4", 32'h0000_7500, 32'h0000_E500, 16'd4, 16'd4, 0, -1, 0, -1, 0);     // zero count
    runCase("R11", 32'h0000_2000, 32'h0000_9000, 16'd4, 16'hFFFC, 3, 0, 0, -1, 0);  // repeat faulted run
    runCase("R11", 32'h0000_4000, 32'h0000_B000, 16'd4, 16'd4, 3, 1, 0, -1, 0);
    runCase("R1", 32'h0000_7600, 32'h0000_E600, 16'd4, 16'd4, 5, -1, 0, -1, 1);     // start while busy

    for (int r = 0; r < 25; r++) begin
      int n, mode, idx;
      logic [15:0] so, dof;
      n    = 1 + int'($urandom % 12);
      so   = 16'(($urandom % 17) * 4) - 16'd32;
      dof  = 16'(($urandom % 17) * 4) - 16'd32;
      mode = int'($urandom % 4);
      idx  = int'($urandom % (2 * n));
      case (mode)
        0: runCase("R2", $urandom, $urandom, so, dof, n, -1, 0, -1, 0);
        1: runCase((idx % 2 == 0) ? "R5" : "R6", $urandom, $urandom, so, dof, n, idx, 0, -1, 0);
        2: runCase("R7", $urandom, $urandom, so, dof, n, -1, 1, idx, 0);
        default: runCase("R9", $urandom, $urandom, so, dof, n, -1, 2, idx, 0);
      endcase
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule